// File: doc/BRIEF.md
# Armed Two-Write Software Reset Controller

This block sits behind a register write port and watches for writes to one software clear register. It recognises that register by a fixed command byte. Each accepted 16-bit data word can ask for any mix of single-cycle clear strobes. These strobes go to the alarm registers, the lookup cache, the FIFO and the two DAC channels.

The same register also carries a full-reset request. That request only takes effect as a two-step sequence. An arming word must come first, and a firing word must follow it. An unarmed firing word does nothing. Any other accepted write drops the armed state.

Once a full reset fires, the block sends out a one-clock full-reset strobe and raises `busy`. It then runs a sequencer that writes zero to every internal RAM address, one address per clock, and lowers `busy` when the walk is done. Writes that arrive while `busy` is high are dropped. A cache-clear request also raises a sticky recompute flag. The flag tells the sample path that the next sample must redo the table lookup and the DAC code calculation, and the sample path acknowledges it with `sample_tick`.

Top module: `swclr_ctrl`

## Requirements
- R1: A write is accepted only when `wr_en` is high and `wr_cmd` equals 8'h74. A write with any other command byte produces no strobe and leaves the armed state unchanged.
- R2: Data bits 15 to 7 have no effect on any output.
- R3: An accepted word with bit 6 = 0 and bit 5 = 1 arms the block. An accepted word with bit 6 = 1 and bit 5 = 0 fires a full reset only if the block is armed. Without a prior arm, that word causes no full reset.
- R4: Every accepted word that is not an arming word leaves the block disarmed. This includes the firing word itself, a word with bits 6 and 5 both set, and a word that only carries clear bits.
- R5: `full_rst` is high for exactly one clock, in the cycle after the clock edge that accepts the firing write. `busy` rises in that same cycle.
- R6: `busy` stays high for RAM_DEPTH+1 cycles. In the last RAM_DEPTH of those cycles, `ram_we` is high, `ram_addr` steps from 0 to RAM_DEPTH-1, and `ram_wdata` is zero.
- R7: Writes presented while `busy` is high produce no strobe and cannot arm the block.
- R8: For an accepted word, the strobes map as follows: bit 4 gives `alarm_clr`, bit 3 gives `cache_clr`, bit 2 gives `fifo_clr`, bit 1 gives `dac2_clr`, and bit 0 gives `dac1_clr`. Each strobe is high for one clock, in the cycle after the accepting edge. Any combination may be set in one word, including in a firing word.
- R9: A cache clear sets `recompute` in the same cycle as its strobe. `recompute` then holds until a clock edge that has `sample_tick` high. A new cache clear at that edge wins over `sample_tick`. A full reset clears `recompute`.
- R10: While `rst` is held, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_cmd | input | 8 | Command byte of the write |
| wr_data | input | 16 | Data word of the write |
| sample_tick | input | 1 | Sample path has consumed the recompute request |
| full_rst | output | 1 | One-clock full-reset strobe |
| busy | output | 1 | Full reset and RAM initialisation in progress |
| alarm_clr | output | 1 | Clear alarm thresholds and alarm flags |
| cache_clr | output | 1 | Clear table pointers and lookup cache |
| fifo_clr | output | 1 | Reset FIFO pointers and contents |
| dac2_clr | output | 1 | Reset channel 2 DAC registers |
| dac1_clr | output | 1 | Reset channel 1 DAC registers |
| recompute | output | 1 | Force a lookup and code calculation on the next sample |
| ram_we | output | 1 | Initialisation write enable |
| ram_addr | output | ADDR_W (6) | Initialisation address |
| ram_wdata | output | RAM_DW (16) | Initialisation data, always zero |

## Verification
A firing word that also carries clear bits makes the full-reset strobe and the clear strobes land in the same cycle, and the sequencer start with them. The stimulus table includes such a word (fire + alarm + FIFO). Its expected strobes and full reset are compared at the sampling point one cycle after the write. After that, the `busy` length and the address walk are checked. A second collision is between a cache clear and `sample_tick` at the same edge. There the bench expects `recompute` to stay set.

// File: rtl/swclr_pkg.sv
package swclr_pkg;

    localparam int WORD_W   = 16;
    localparam int CMD_W    = 8;
    localparam int CLR_N    = 5;

    // Bit positions inside the written word; the sequence logic depends on them
    localparam int B_FIRE   = 6;
    localparam int B_ARM    = 5;
    localparam int B_ALARM  = 4;
    localparam int B_CACHE  = 3;
    localparam int B_FIFO   = 2;
    localparam int B_DAC2   = 1;
    localparam int B_DAC1   = 0;

    // Index of each strobe inside the packed clear vector
    localparam int I_DAC1   = 0;
    localparam int I_DAC2   = 1;
    localparam int I_FIFO   = 2;
    localparam int I_CACHE  = 3;
    localparam int I_ALARM  = 4;

    typedef struct packed {
        logic alarm;
        logic cache;
        logic fifo;
        logic dac2;
        logic dac1;
    } clr_set_t;

    typedef struct packed {
        logic     arm;
        logic     fire;
        clr_set_t clr;
    } word_req_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_FIRE = 2'd1,
        SEQ_FILL = 2'd2
    } seq_st_t;

    function automatic word_req_t decode_word(input logic [B_FIRE:0] d);
        word_req_t r;
        r.arm       = ~d[B_FIRE] &  d[B_ARM];
        r.fire      =  d[B_FIRE] & ~d[B_ARM];
        r.clr.alarm =  d[B_ALARM];
        r.clr.cache =  d[B_CACHE];
        r.clr.fifo  =  d[B_FIFO];
        r.clr.dac2  =  d[B_DAC2];
        r.clr.dac1  =  d[B_DAC1];
        return r;
    endfunction

endpackage

// File: rtl/swclr_arm.sv
module swclr_arm
    import swclr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  word_req_t req,
    output logic      armed,
    output logic      fire
);

    logic armed_q;

    // Fire only when a firing word meets an already-armed flag
    assign fire  = accept & req.fire & armed_q;
    assign armed = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (accept) begin
            armed_q <= req.arm;
        end
    end

    // R4: a non-arming accepted word leaves the flag clear
    p_disarm_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && !req.arm) |=> !armed_q);

    // R3: an arming word always leaves the flag set
    p_arm_set_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && req.arm) |=> armed_q);

endmodule

// File: rtl/swclr_pulse.sv
module swclr_pulse
    import swclr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  clr_set_t req_clr,
    input  logic     full_rst,
    input  logic     sample_tick,
    output clr_set_t clr_q,
    output logic     recompute
);

    logic [CLR_N-1:0] req_vec;
    logic [CLR_N-1:0] pulse_q;
    logic             recompute_q;

    assign req_vec = req_clr;

    genvar gi;
    generate
        for (gi = 0; gi < CLR_N; gi++) begin : g_strobe
            always_ff @(posedge clk) begin
                if (rst) begin
                    pulse_q[gi] <= 1'b0;
                end else begin
                    pulse_q[gi] <= accept & req_vec[gi];
                end
            end
        end
    endgenerate

    assign clr_q = pulse_q;

    // Priority: reset / full reset, then a new cache clear, then the sample ack
    always_ff @(posedge clk) begin
        if (rst || full_rst) begin
            recompute_q <= 1'b0;
        end else if (accept && req_clr.cache) begin
            recompute_q <= 1'b1;
        end else if (sample_tick) begin
            recompute_q <= 1'b0;
        end
    end

    assign recompute = recompute_q;

    // R9: the flag persists until acknowledged or wiped by a full reset
    p_recompute_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(recompute_q) && !$past(sample_tick) && !$past(full_rst)) |-> recompute_q);

    // R9: a cache strobe is always accompanied by the flag
    p_recompute_set_r9: assert property (@(posedge clk) disable iff (rst)
        pulse_q[I_CACHE] |-> recompute_q);

endmodule

// File: rtl/swclr_init_seq.sv
module swclr_init_seq
    import swclr_pkg::*;
#(
    parameter int RAM_DEPTH = 64,
    parameter int RAM_DW    = 16,
    localparam int ADDR_W   = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    output logic              full_rst,
    output logic              busy,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [RAM_DW-1:0] ram_wdata
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(RAM_DEPTH - 1);

    seq_st_t           st_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            addr_q <= '0;
        end else begin
            unique case (st_q)
                SEQ_IDLE: begin
                    if (fire) begin
                        st_q <= SEQ_FIRE;
                    end
                end
                SEQ_FIRE: begin
                    st_q   <= SEQ_FILL;
                    addr_q <= '0;
                end
                SEQ_FILL: begin
                    if (addr_q == LAST_ADDR) begin
                        st_q   <= SEQ_IDLE;
                        addr_q <= '0;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: begin
                    st_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign full_rst  = (st_q == SEQ_FIRE);
    assign busy      = (st_q != SEQ_IDLE);
    assign ram_we    = (st_q == SEQ_FILL);
    assign ram_addr  = addr_q;
    assign ram_wdata = '0;

    // R5: the full-reset strobe lasts a single clock
    p_full_single_r5: assert property (@(posedge clk) disable iff (rst)
        full_rst |=> !full_rst);

    // R6: the RAM walk starts at address zero right after the strobe
    p_fill_start_r6: assert property (@(posedge clk) disable iff (rst)
        full_rst |=> (ram_we && ram_addr == '0));

    // R6: consecutive init writes step the address by one
    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1));

endmodule

// File: rtl/swclr_ctrl.sv
module swclr_ctrl
    import swclr_pkg::*;
#(
    parameter logic [7:0] CMD_CODE  = 8'h74,
    parameter int         RAM_DEPTH = 64,
    parameter int         RAM_DW    = 16,
    localparam int        ADDR_W    = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_cmd,
    input  logic [15:0]       wr_data,
    input  logic              sample_tick,
    output logic              full_rst,
    output logic              busy,
    output logic              alarm_clr,
    output logic              cache_clr,
    output logic              fifo_clr,
    output logic              dac2_clr,
    output logic              dac1_clr,
    output logic              recompute,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [RAM_DW-1:0] ram_wdata
);

    word_req_t req;
    clr_set_t  clr_q;
    logic      accept;
    logic      armed;
    logic      fire;
    logic      dont_care_unused;

    // Upper data bits carry no meaning for this register
    assign dont_care_unused = ^wr_data[WORD_W-1:B_FIRE+1];

    assign req    = decode_word(wr_data[B_FIRE:0]);
    assign accept = wr_en & (wr_cmd == CMD_CODE) & ~busy;

    swclr_arm u_arm (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .req    (req),
        .armed  (armed),
        .fire   (fire)
    );

    swclr_pulse u_pulse (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .req_clr     (req.clr),
        .full_rst    (full_rst),
        .sample_tick (sample_tick),
        .clr_q       (clr_q),
        .recompute   (recompute)
    );

    swclr_init_seq #(
        .RAM_DEPTH (RAM_DEPTH),
        .RAM_DW    (RAM_DW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .full_rst  (full_rst),
        .busy      (busy),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    assign alarm_clr = clr_q.alarm;
    assign cache_clr = clr_q.cache;
    assign fifo_clr  = clr_q.fifo;
    assign dac2_clr  = clr_q.dac2;
    assign dac1_clr  = clr_q.dac1;

    // R3: a full reset is only ever preceded by an armed flag
    p_fire_after_arm_r3: assert property (@(posedge clk) disable iff (rst)
        full_rst |-> $past(armed));

    // R5: busy accompanies the full-reset strobe
    p_busy_with_full_r5: assert property (@(posedge clk) disable iff (rst)
        full_rst |-> busy);

    // R7: nothing presented during busy turns into a strobe
    p_quiet_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> (clr_q == '0));

    // R6: init writes happen only inside the busy window
    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> busy);

endmodule

// File: tb/swclr_ctrl_tb.sv
module swclr_ctrl_tb;

    localparam int RAM_DEPTH = 64;
    localparam int ADDR_W    = $clog2(RAM_DEPTH);
    localparam int N_VEC     = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [7:0]        wr_cmd;
    logic [15:0]       wr_data;
    logic              sample_tick;
    logic              full_rst, busy, recompute, ram_we;
    logic              alarm_clr, cache_clr, fifo_clr, dac2_clr, dac1_clr;
    logic [ADDR_W-1:0] ram_addr;
    logic [15:0]       ram_wdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    swclr_ctrl #(.RAM_DEPTH(RAM_DEPTH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .sample_tick(sample_tick), .full_rst(full_rst), .busy(busy),
        .alarm_clr(alarm_clr), .cache_clr(cache_clr), .fifo_clr(fifo_clr),
        .dac2_clr(dac2_clr), .dac1_clr(dac1_clr), .recompute(recompute),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    // Entry: cmd[29:22] data[21:6] strobes{alarm,cache,fifo,dac2,dac1}[5:1] fire[0]
    localparam logic [29:0] VEC [N_VEC] = '{
        {8'h74, 16'h001F, 5'b11111, 1'b0},  // R8 all strobes
        {8'h74, 16'h0020, 5'b00000, 1'b0},  // R3 arm
        {8'h74, 16'h0040, 5'b00000, 1'b1},  // R3 fire after arm
        {8'h74, 16'h0040, 5'b00000, 1'b0},  // R3 fire without arm
        {8'h74, 16'h0020, 5'b00000, 1'b0},  // R3 arm
        {8'h75, 16'h0040, 5'b00000, 1'b0},  // R1 wrong command ignored
        {8'h74, 16'hFFC0, 5'b00000, 1'b1},  // R1 R2 arm survived, high bits ignored
        {8'h74, 16'h0020, 5'b00000, 1'b0},  // R3 arm
        {8'h74, 16'h0001, 5'b00001, 1'b0},  // R4 R8 clear-only disarms
        {8'h74, 16'h0040, 5'b00000, 1'b0},  // R4 no fire
        {8'h74, 16'h0020, 5'b00000, 1'b0},  // R3 arm
        {8'h74, 16'h0060, 5'b00000, 1'b0},  // R4 both bits: neither
        {8'h74, 16'h0040, 5'b00000, 1'b0},  // R4 no fire
        {8'h74, 16'h0024, 5'b00100, 1'b0},  // R8 arm with fifo strobe
        {8'h74, 16'h0054, 5'b10100, 1'b1},  // R5 R8 fire with alarm and fifo
        {8'h33, 16'h001F, 5'b00000, 1'b0}   // R1 wrong command ignored
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] strobes();
        return {alarm_clr, cache_clr, fifo_clr, dac2_clr, dac1_clr};
    endfunction

    // Drive at a falling edge; return at the next falling edge, where results show
    task automatic do_write(input logic [7:0] c, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = c; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_cmd = '0; wr_data = '0;
    endtask

    // Called in the first busy cycle; follows the whole busy window
    task automatic check_busy_window(input string tag);
        int cyc = 0;
        int bad = 0;
        while (busy && cyc < 1000) begin
            if (cyc == 0) begin
                if (ram_we) bad++;
            end else begin
                if (!ram_we || ram_addr != ADDR_W'(cyc - 1) || ram_wdata != '0) bad++;
            end
            cyc++;
            @(negedge clk);
        end
        chk(cyc == RAM_DEPTH + 1, {"R6 busy length ", tag}, cyc, RAM_DEPTH + 1);
        chk(bad == 0, {"R6 address walk ", tag}, bad, 0);
        chk(!ram_we && !full_rst, {"R6 idle after init ", tag}, {ram_we, full_rst}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_cmd = '0; wr_data = '0; sample_tick = 1'b0;
        repeat (5) @(negedge clk);
        // R10: outputs low while reset is held
        chk({full_rst, busy, strobes(), recompute, ram_we} == '0, "R10 reset state",
            {full_rst, busy, strobes(), recompute, ram_we}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < N_VEC; i++) begin
            do_write(VEC[i][29:22], VEC[i][21:6]);
            chk(strobes() == VEC[i][5:1], $sformatf("R8 strobes vec %0d", i),
                strobes(), VEC[i][5:1]);
            chk(full_rst == VEC[i][0], $sformatf("R3 full reset vec %0d", i),
                full_rst, VEC[i][0]);
            if (VEC[i][0]) begin
                chk(busy, $sformatf("R5 busy rises vec %0d", i), busy, 1);
                check_busy_window($sformatf("vec %0d", i));
            end
            @(negedge clk);
            chk(strobes() == '0 && !full_rst, $sformatf("R8 single cycle vec %0d", i),
                {strobes(), full_rst}, 0);
        end

        // R9: cache clear sets the flag, which holds until sample_tick
        do_write(8'h74, 16'h0008);
        chk(cache_clr && recompute, "R9 cache strobe sets flag", {cache_clr, recompute}, 2'b11);
        repeat (3) @(negedge clk);
        chk(recompute && !cache_clr, "R9 flag holds", {cache_clr, recompute}, 2'b01);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        chk(!recompute, "R9 flag cleared by sample_tick", recompute, 0);

        // R9: a cache clear at the same edge as sample_tick wins
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = 8'h74; wr_data = 16'h0008; sample_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_cmd = '0; wr_data = '0; sample_tick = 1'b0;
        chk(recompute, "R9 set wins over sample_tick", recompute, 1);

        // R9: full reset wipes the flag; R7: writes during busy are dropped
        do_write(8'h74, 16'h0020);
        do_write(8'h74, 16'h0040);
        chk(full_rst && busy, "R5 fire with flag set", {full_rst, busy}, 2'b11);
        do_write(8'h74, 16'h001F);
        chk(strobes() == '0, "R7 write during busy", strobes(), 0);
        do_write(8'h74, 16'h0020);
        chk(strobes() == '0, "R7 arm during busy", strobes(), 0);
        while (busy) @(negedge clk);
        chk(!recompute, "R9 full reset clears flag", recompute, 0);
        do_write(8'h74, 16'h0040);
        chk(!full_rst && !busy, "R7 arm during busy had no effect", {full_rst, busy}, 0);

        // R10: reset mid-sequence returns outputs low
        do_write(8'h74, 16'h0020);
        do_write(8'h74, 16'h0048);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk({full_rst, busy, strobes(), recompute, ram_we} == '0, "R10 reset during init",
            {full_rst, busy, strobes(), recompute, ram_we}, 0);
        rst = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule